// File: doc/BRIEF.md
# Prescaled Timer Counter

A 32-bit up-counter for a peripheral clock domain. A programmable prescaler sits in front of it. The prescale counter advances on every clock while counting is enabled. When it reaches the value held in the prescale register, the main timer counter steps by one and the prescale counter starts again from zero on the same edge. A prescale value of p therefore advances the timer once every p+1 clocks.

Software reaches the block through a plain synchronous register port: an address, a write strobe with write data, and a read data output decoded combinationally from the address. Four compare registers watch the timer counter and each sets its own interrupt flag. A capture input loads the current count into a capture register. All flags are ORed onto a single interrupt line and are cleared by writing ones to them.

The control register holds two bits. Bit 0 lets both counters run. Bit 1 forces both counters to zero for as long as it stays set.

Top module: `presc_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: With the run bit (control bit 0) set and the clear bit (control bit 1) low, the prescale counter (offset 0x10) goes 0,1,...,p with p the prescale register (offset 0x0C). On the edge where it equals p, the timer counter (offset 0x08) increments and the prescale counter returns to 0. After n running edges from zero, the timer reads n/(p+1) and the prescale counter reads n mod (p+1).
- R3: With control bit 0 low, both counters keep their values.
- R4: On the first edge after control bit 1 is set, both counters go to zero. They stay zero while it is set, even when written, and resume once it is cleared.
- R5: The timer counter wraps from 0xFFFFFFFF to 0. The wrap sets no flag.
- R6: Match register k (offset 0x18+4k, k=0..3) sets flag bit k of the flag register (offset 0x00) on an increment edge where the timer counter, before the step, equals it.
- R7: A rising edge of `cap_in` passes through a two-flop synchronizer. On the third clock edge after the rise, the current timer value is loaded into the capture register (offset 0x2C) and flag bit 4 is set. A falling edge does nothing.
- R8: Writing 1 to a flag bit clears it and writing 0 leaves it. A flag set on the same edge as its clear stays set.
- R9: `irq` is high exactly when any flag bit is set.
- R10: The control register (offset 0x04) keeps 2 bits and the flag register keeps 5. All other bits read 0. The prescale, match and timer registers hold full 32-bit values. Unmapped offsets read 0 and ignore writes.
- R11: A bus write to the timer or prescale counter wins over an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | peripheral clock |
| rst_n | input | 1 | asynchronous reset, active low |
| addr | input | 6 | register byte offset |
| wr_en | input | 1 | write strobe, sampled on the rising edge |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data for `addr`, combinational |
| cap_in | input | 1 | asynchronous capture request |
| irq | output | 1 | OR of all flag bits |

## Verification
The hardest case to reach is a write-one-to-clear that lands on the same edge as a new match on the flag it clears. To set it up, the bench first sets the flag and then parks the counter a known distance below the match value with the prescaler at zero. It enables counting and issues the clear write on exactly the edge where the match fires, counting edges from the enable. The prescaler sweep is equally edge-exact. Each run starts from zeroed counters, and the bench ends it with a disable write whose own edge still counts.

// File: rtl/presc_timer.sv
module presc_timer #(
  parameter int W    = 32,
  parameter int AW   = 6,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          cap_in,
  output logic          irq
);
  localparam int NM = 4;
  localparam int NF = NM + 1;
  localparam logic [AW-1:0] A_FLG = AW'(8'h00);
  localparam logic [AW-1:0] A_CTL = AW'(8'h04);
  localparam logic [AW-1:0] A_TC  = AW'(8'h08);
  localparam logic [AW-1:0] A_PR  = AW'(8'h0C);
  localparam logic [AW-1:0] A_PC  = AW'(8'h10);
  localparam logic [AW-1:0] A_MR  = AW'(8'h18);
  localparam logic [AW-1:0] A_CAP = AW'(8'h2C);

  logic [NF-1:0] flags;
  logic [1:0]    ctl;
  logic [W-1:0]  tc, pr, pc, capr;
  logic [W-1:0]  mr [NM];
  logic [SYNC:0] csync;
  logic [NF-1:0] set_v;

  wire run     = ctl[0] & ~ctl[1];
  wire tick    = run & (pc == pr);
  wire wr_tc   = wr_en & (addr == A_TC);
  wire wr_pc   = wr_en & (addr == A_PC);
  wire wr_flg  = wr_en & (addr == A_FLG);
  wire cap_rise = csync[SYNC-1] & ~csync[SYNC];

  always_comb begin
    set_v = '0;
    for (int k = 0; k < NM; k++) set_v[k] = tick & (tc == mr[k]);
    set_v[NM] = cap_rise;
  end

  assign irq = |flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; pr <= '0; flags <= '0; capr <= '0; csync <= '0;
      for (int k = 0; k < NM; k++) mr[k] <= '0;
    end else begin
      csync <= {csync[SYNC-1:0], cap_in};
      if (wr_en && addr == A_CTL) ctl <= wdata[1:0];
      if (wr_en && addr == A_PR)  pr  <= wdata;
      for (int k = 0; k < NM; k++)
        if (wr_en && addr == A_MR + AW'(4*k)) mr[k] <= wdata;
      if (cap_rise) capr <= tc;
      flags <= (flags & ~(wr_flg ? wdata[NF-1:0] : '0)) | set_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc <= '0; pc <= '0;
    end else if (ctl[1]) begin
      tc <= '0; pc <= '0;
    end else begin
      if (wr_tc)      tc <= wdata;
      else if (tick)  tc <= tc + W'(1);
      if (wr_pc)      pc <= wdata;
      else if (tick)  pc <= '0;
      else if (run)   pc <= pc + W'(1);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_FLG: rdata = W'(flags);
      A_CTL: rdata = W'(ctl);
      A_TC:  rdata = tc;
      A_PR:  rdata = pr;
      A_PC:  rdata = pc;
      A_CAP: rdata = capr;
      default: ;
    endcase
    for (int k = 0; k < NM; k++)
      if (addr == A_MR + AW'(4*k)) rdata = mr[k];
  end

  // R4
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[1] |=> (tc == '0) && (pc == '0));

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[0] && !ctl[1] && !wr_en) |=> $stable(tc) && $stable(pc));

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[1] && !wr_tc) |=> (tc == $past(tc)) || (tc == $past(tc) + W'(1)));

  // R2
  presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_pc) |=> pc == '0);

  // R7
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> flags[NM] && (capr == $past(tc)));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|set_v));
endmodule

// File: tb/presc_timer_test.sv
module presc_timer_test;
  logic clk = 0, rst_n = 0, wr_en = 0, cap_in = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata, v;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  presc_timer uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2); rst_n = 1; idle(1);
    // R1 reset state
    for (int a = 0; a < 64; a += 4) begin rd(6'(a), v); chk("R1", v, 0); end
    chk("R1 irq", 32'(irq), 0);

    // R10 register map and reserved bits
    wr(6'h0C, 32'hDEADBEEF); rd(6'h0C, v); chk("R10 pr", v, 32'hDEADBEEF);
    for (int k = 0; k < 4; k++) begin
      wr(6'(8'h18 + 4*k), 32'h100 + k); rd(6'(8'h18 + 4*k), v); chk("R10 mr", v, 32'h100 + k);
    end
    wr(6'h14, 32'hFFFFFFFF); rd(6'h14, v); chk("R10 gap", v, 0);
    wr(6'h28, 32'hFFFFFFFF); rd(6'h28, v); chk("R10 gap", v, 0);
    wr(6'h30, 32'hFFFFFFFF); rd(6'h30, v); chk("R10 gap", v, 0);
    wr(6'h04, 32'hFFFFFFFC); rd(6'h04, v); chk("R10 ctl", v, 0);
    wr(6'h00, 32'hFFFFFFFF); rd(6'h00, v); chk("R10 flg", v, 0);

    // R2 prescale sweep
    for (int p = 0; p < 4; p++) begin
      for (int n = 1; n <= 9; n++) begin
        wr(6'h0C, p); wr(6'h08, 0); wr(6'h10, 0);
        wr(6'h04, 1); idle(n - 1); wr(6'h04, 0);
        rd(6'h08, v); chk("R2 tc", v, n / (p + 1));
        rd(6'h10, v); chk("R2 pc", v, n % (p + 1));
      end
    end

    // R3 disabled counters hold
    wr(6'h0C, 2); wr(6'h08, 77); wr(6'h10, 1); idle(6);
    rd(6'h08, v); chk("R3 tc", v, 77);
    rd(6'h10, v); chk("R3 pc", v, 1);

    // R4 clear bit
    wr(6'h04, 3); idle(1);
    rd(6'h08, v); chk("R4 tc", v, 0);
    rd(6'h10, v); chk("R4 pc", v, 0);
    wr(6'h08, 55); idle(3);
    rd(6'h08, v); chk("R4 held", v, 0);
    wr(6'h0C, 0); wr(6'h04, 1); idle(3); wr(6'h04, 0);
    rd(6'h08, v); chk("R4 resume", v, 4);

    // R5 wrap raises no flag
    for (int k = 0; k < 4; k++) wr(6'(8'h18 + 4*k), 5);
    wr(6'h08, 32'hFFFFFFFE); wr(6'h04, 1); idle(1); wr(6'h04, 0);
    rd(6'h08, v); chk("R5 wrap", v, 0);
    rd(6'h00, v); chk("R5 flag", v, 0);
    chk("R5 irq", 32'(irq), 0);

    // R6 match boundary
    wr(6'h1C, 3); wr(6'h08, 0);
    wr(6'h04, 1); idle(2); wr(6'h04, 0);
    rd(6'h00, v); chk("R6 early", v, 0);
    wr(6'h04, 1); wr(6'h04, 0);
    rd(6'h00, v); chk("R6 hit", v, 32'h2);
    chk("R9 irq set", 32'(irq), 1);
    // R8 write zero keeps, write one clears
    wr(6'h00, 32'hFFFFFFFD); rd(6'h00, v); chk("R8 keep", v, 32'h2);
    wr(6'h00, 32'h2); rd(6'h00, v); chk("R8 clear", v, 0);
    chk("R9 irq clr", 32'(irq), 0);
    // R6 overflow detect through match 3
    wr(6'h24, 32'hFFFFFFFF); wr(6'h08, 32'hFFFFFFFF);
    wr(6'h04, 1); wr(6'h04, 0);
    rd(6'h00, v); chk("R6 ovf", v, 32'h8);
    wr(6'h00, 32'h8);

    // R8 set wins over same-edge clear
    wr(6'h20, 20); wr(6'h08, 20); wr(6'h04, 1); wr(6'h04, 0);
    rd(6'h00, v); chk("R6 mr2", v, 32'h4);
    wr(6'h08, 18); wr(6'h04, 1); idle(2); wr(6'h00, 32'h4); wr(6'h04, 0);
    rd(6'h00, v); chk("R8 set wins", v, 32'h4);
    rd(6'h08, v); chk("R8 tc", v, 22);
    wr(6'h00, 32'h4);

    // R11 write beats increment
    wr(6'h20, 5); wr(6'h08, 0); wr(6'h04, 1); wr(6'h08, 500);
    rd(6'h08, v); chk("R11 tc", v, 500);
    idle(1); rd(6'h08, v); chk("R11 next", v, 501);
    wr(6'h0C, 3); wr(6'h10, 2); rd(6'h10, v); chk("R11 pc", v, 2);
    wr(6'h04, 0);

    // R7 capture
    wr(6'h08, 1234); wr(6'h00, 32'h1F);
    cap_in = 1; idle(2);
    rd(6'h00, v); chk("R7 early", v, 0);
    idle(1);
    rd(6'h00, v); chk("R7 flag", v, 32'h10);
    rd(6'h2C, v); chk("R7 value", v, 1234);
    chk("R9 irq cap", 32'(irq), 1);
    wr(6'h00, 32'h10); wr(6'h08, 99); cap_in = 0; idle(5);
    rd(6'h00, v); chk("R7 fall", v, 0);
    rd(6'h2C, v); chk("R7 kept", v, 1234);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule